// File: doc/BRIEF.md
# Keyed-Access Seconds Watchdog

This block is a watchdog timer counted in whole seconds and programmed over a byte-wide I/O bus. Two neighbouring port addresses form an index/data pair: software writes a register number to the lower port and then reads or writes that register through the upper port. The pair starts out locked. It opens only after a fixed four-byte key has been written to the lower port, and it locks again when software writes the exit command.

Inside the unlocked space there are two read-only identity bytes, a device-select register, and three watchdog registers: a control byte and a 16-bit timeout split over two byte registers. The watchdog registers respond only while the watchdog's device number is selected. Writing the high timeout byte reloads the counter with the full 16-bit value, which starts or refreshes the countdown. A zero value stops the countdown at once. A prescaler derives a one-second tick from the system clock. When the count runs out, the block emits a single-cycle pulse on either a reset output or a non-maskable-interrupt output and then disarms.

Top module: `wdt_cfg_port`

## Requirements
- R1: The index port is at BASE_ADDR and the data port at BASE_ADDR+1. When the pair is open, a read of the index port returns the current index. A read at any other address returns 0x00.
- R2: The pair opens after the bytes 0x87, 0x01, 0x55 and a final key byte are written in that order to the index port. The final byte is 0xAA when BASE_ADDR is 0x4E and 0x55 otherwise. A byte that does not match the expected key byte sends the sequence back to its first step.
- R3: While the pair is locked, data-port writes have no effect, and reads of either port return 0xFF.
- R4: When open, index 0x20 reads 0x87 and index 0x21 reads 0x21. Index 0x07 is a device-select byte that reads back its last written value.
- R5: Indexes 0x72, 0x73 and 0x74 are active only while the device-select byte equals DEV_NUM (default 0x07). Otherwise they read 0x00 and writes to them are ignored.
- R6: A write to 0x73 only stores the low timeout byte. A write of H to 0x74 stores H and loads the count {H, low byte}. A non-zero value arms the timer and a zero value disarms it at once.
- R7: A free-running prescaler ticks once every CLK_PER_SEC cycles, with the first tick in cycle CLK_PER_SEC-1 after reset. While the timer is armed, each tick lowers the count by one. The tick at count 1 is the expiry.
- R8: On expiry the timer disarms. If control bit 6 is 1, the clock edge that takes the expiring tick also raises a single-cycle pulse: on the reset output when control bit 7 is 1, on the NMI output when it is 0.
- R9: A data write to index 0x02 with bit 1 set locks the pair again, and the full key is then needed again.
- R10: After reset the pair is locked, and the index, device select, control byte and timeout bytes are 0x00. The timer is disarmed and both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| wdt_rst_o | output | 1 | Single-cycle reset pulse on expiry |
| wdt_nmi_o | output | 1 | Single-cycle NMI pulse on expiry |

## Verification
Key sequences are tried correct and broken at different positions. The broken ones separate a strict restart from a partial match, and a second instance at the alternate base checks that only its own final key byte opens it. The countdown is run with values held only in the low byte, with a value held only in the high byte, and with repeated refreshes and a zero write. These runs separate a reload on the high-byte write from a reload on any write, and a real 16-bit count from an 8-bit one. Expiry is tried with each output selected and with the output disabled, and a cycle-accurate model compares both pulse pins on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        KEY_S0   = 3'd0,
        KEY_S1   = 3'd1,
        KEY_S2   = 3'd2,
        KEY_S3   = 3'd3,
        CFG_OPEN = 3'd4
    } unlock_e;

    localparam logic [7:0] IDX_EXIT  = 8'h02;
    localparam logic [7:0] IDX_DEV   = 8'h07;
    localparam logic [7:0] IDX_ID_A  = 8'h20;
    localparam logic [7:0] IDX_ID_B  = 8'h21;
    localparam logic [7:0] IDX_CTRL  = 8'h72;
    localparam logic [7:0] IDX_TO_LO = 8'h73;
    localparam logic [7:0] IDX_TO_HI = 8'h74;

    localparam logic [7:0] ID_A_VAL  = 8'h87;
    localparam logic [7:0] ID_B_VAL  = 8'h21;

    localparam int CTRL_KIND_BIT = 7;
    localparam int CTRL_EN_BIT   = 6;
    localparam int EXIT_BIT      = 1;

    function automatic logic [7:0] key_byte_at(input logic [1:0] pos, input logic [7:0] last);
        case (pos)
            2'd0:    key_byte_at = 8'h87;
            2'd1:    key_byte_at = 8'h01;
            2'd2:    key_byte_at = 8'h55;
            default: key_byte_at = last;
        endcase
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter logic [7:0] KEY_LAST = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       cfg_open
);

    unlock_e    st_d, st_q;
    logic [7:0] exp_byte;

    always_comb begin
        exp_byte = key_byte_at(st_q[1:0], KEY_LAST);
        st_d     = st_q;
        if (st_q == CFG_OPEN) begin
            if (exit_req) st_d = KEY_S0;
        end else if (key_wr) begin
            if (key_byte != exp_byte) begin
                st_d = KEY_S0;
            end else begin
                case (st_q)
                    KEY_S0:  st_d = KEY_S1;
                    KEY_S1:  st_d = KEY_S2;
                    KEY_S2:  st_d = KEY_S3;
                    default: st_d = CFG_OPEN;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_S0;
        else        st_q <= st_d;
    end

    assign cfg_open = (st_q == CFG_OPEN);

    // R9: an exit request while open locks the pair on the next cycle
    p_exit_relocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && exit_req) |=> !cfg_open);

    // R2: opening is always preceded by the final key byte on the index port
    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(key_wr && (key_byte == KEY_LAST)));

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int CLK_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_SEC - 1);

    logic [CW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (pre_q == LAST);
        pre_d = tick ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R7: ticks never come back to back (CLK_PER_SEC is at least 2)
    p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          out_en,
    input  logic          use_reset,
    output logic          rst_pulse,
    output logic          nmi_pulse
);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          rst;
        logic          nmi;
    } cd_s;

    cd_s cd_d, cd_q;

    always_comb begin
        cd_d     = cd_q;
        cd_d.rst = 1'b0;
        cd_d.nmi = 1'b0;
        if (load) begin
            cd_d.cnt   = load_val;
            cd_d.armed = (load_val != '0);
        end else if (cd_q.armed && tick) begin
            if (cd_q.cnt == CW'(1)) begin
                cd_d.cnt   = '0;
                cd_d.armed = 1'b0;
                cd_d.rst   = out_en && use_reset;
                cd_d.nmi   = out_en && !use_reset;
            end else begin
                cd_d.cnt = cd_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign rst_pulse = cd_q.rst;
    assign nmi_pulse = cd_q.nmi;

    // R8: only one kind of pulse at a time
    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_pulse && nmi_pulse));

    // R8: a pulse lasts a single cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse || nmi_pulse) |=> !(rst_pulse || nmi_pulse));

    // R8: the timer is disarmed once it has fired
    p_fired_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse || nmi_pulse) |-> !cd_q.armed);

    // R6: zero load stops the timer at once
    p_zero_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val == '0)) |=> !cd_q.armed);

    // R6: non-zero load arms with the loaded value
    p_load_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val != '0)) |=> (cd_q.armed && (cd_q.cnt == $past(load_val))));

    // R7: each tick while armed lowers the count by one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q.armed && tick && !load && (cd_q.cnt > CW'(1))) |=> (cd_q.cnt == $past(cd_q.cnt) - 1'b1));

endmodule

// File: rtl/wdt_cfg_port.sv
module wdt_cfg_port
    import wdt_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = ADDR_W'(16'h002E),
    parameter logic [7:0]        DEV_NUM     = 8'h07,
    parameter int                CLK_PER_SEC = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              wdt_rst_o,
    output logic              wdt_nmi_o
);

    localparam int                TO_W      = 16;
    localparam logic [ADDR_W-1:0] ALT_BASE  = ADDR_W'(16'h004E);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1'b1);
    localparam logic [7:0]        KEY_LAST  = (BASE_ADDR == ALT_BASE) ? 8'hAA : 8'h55;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] dev;
        logic [7:0] ctrl;
        logic [7:0] to_lo;
        logic [7:0] to_hi;
    } regs_s;

    regs_s           r_d, r_q;
    logic            hit_idx, hit_dat, cfg_open, wdt_sel;
    logic            exit_req, load, tick;
    logic [TO_W-1:0] load_val;
    logic [7:0]      rd_val;

    wdt_unlock #(.KEY_LAST(KEY_LAST)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (io_wr && hit_idx),
        .key_byte (io_wdata),
        .exit_req (exit_req),
        .cfg_open (cfg_open)
    );

    wdt_tick #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wdt_countdown #(.CW(TO_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .load_val  (load_val),
        .out_en    (r_q.ctrl[CTRL_EN_BIT]),
        .use_reset (r_q.ctrl[CTRL_KIND_BIT]),
        .rst_pulse (wdt_rst_o),
        .nmi_pulse (wdt_nmi_o)
    );

    always_comb begin
        hit_idx  = (io_addr == BASE_ADDR);
        hit_dat  = (io_addr == DATA_ADDR);
        wdt_sel  = (r_q.dev == DEV_NUM);
        load_val = {io_wdata, r_q.to_lo};
        r_d      = r_q;
        exit_req = 1'b0;
        load     = 1'b0;
        if (io_wr && cfg_open && hit_idx) begin
            r_d.idx = io_wdata;
        end
        if (io_wr && cfg_open && hit_dat) begin
            case (r_q.idx)
                IDX_EXIT:  exit_req = io_wdata[EXIT_BIT];
                IDX_DEV:   r_d.dev  = io_wdata;
                IDX_CTRL:  if (wdt_sel) r_d.ctrl  = io_wdata;
                IDX_TO_LO: if (wdt_sel) r_d.to_lo = io_wdata;
                IDX_TO_HI: if (wdt_sel) begin
                    r_d.to_hi = io_wdata;
                    load      = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = 8'h00;
        if (hit_idx) begin
            rd_val = cfg_open ? r_q.idx : 8'hFF;
        end else if (hit_dat) begin
            if (!cfg_open) begin
                rd_val = 8'hFF;
            end else begin
                case (r_q.idx)
                    IDX_DEV:   rd_val = r_q.dev;
                    IDX_ID_A:  rd_val = ID_A_VAL;
                    IDX_ID_B:  rd_val = ID_B_VAL;
                    IDX_CTRL:  rd_val = wdt_sel ? r_q.ctrl  : 8'h00;
                    IDX_TO_LO: rd_val = wdt_sel ? r_q.to_lo : 8'h00;
                    IDX_TO_HI: rd_val = wdt_sel ? r_q.to_hi : 8'h00;
                    default:   rd_val = 8'h00;
                endcase
            end
        end
        io_rdata = io_rd ? rd_val : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3: no register moves while the pair is locked
    p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(r_q.dev) && $stable(r_q.ctrl) && $stable(r_q.to_lo) && $stable(r_q.to_hi)));

    // R5: watchdog registers hold while another device is selected
    p_foreign_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_sel |=> ($stable(r_q.ctrl) && $stable(r_q.to_lo) && $stable(r_q.to_hi)));

endmodule

// File: tb/sim_wdt_cfg_port.sv
`timescale 1ns/1ps
module sim_wdt_cfg_port;

    localparam int          N    = 4;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] ALT  = 16'h004E;
    localparam logic [7:0]  DEVN = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rdata0, rdata1;
    logic        rst0, nmi0, rst1, nmi1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int n_rst = 0;
    int n_nmi = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_cfg_port #(.CLK_PER_SEC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata0), .wdt_rst_o(rst0), .wdt_nmi_o(nmi0)
    );

    wdt_cfg_port #(.BASE_ADDR(ALT), .CLK_PER_SEC(N)) u1 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata1), .wdt_rst_o(rst1), .wdt_nmi_o(nmi1)
    );

    // behavioural reference for u0
    int        m_stage, m_presc, m_cnt;
    bit        m_armed, m_rst, m_nmi;
    bit [7:0]  m_idx, m_dev, m_ctrl, m_lo, m_hi;

    function automatic bit [7:0] key_of(int pos);
        case (pos)
            0: return 8'h87;
            1: return 8'h01;
            2: return 8'h55;
            default: return 8'h55;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_presc = 0; m_cnt = 0; m_armed = 0; m_rst = 0; m_nmi = 0;
            m_idx = 0; m_dev = 0; m_ctrl = 0; m_lo = 0; m_hi = 0;
        end else begin
            bit t, ld, open;
            bit [7:0] ctrl_old;
            int val;
            t = (m_presc == N - 1);
            m_presc = t ? 0 : m_presc + 1;
            open = (m_stage == 4);
            ctrl_old = m_ctrl;
            ld = 0; val = 0;
            m_rst = 0; m_nmi = 0;
            if (io_wr && io_addr == BASE) begin
                if (open) m_idx = io_wdata;
                else if (io_wdata == key_of(m_stage)) m_stage = m_stage + 1;
                else m_stage = 0;
            end
            if (io_wr && io_addr == BASE + 1 && open) begin
                if (m_idx == 8'h02 && io_wdata[1]) m_stage = 0;
                else if (m_idx == 8'h07) m_dev = io_wdata;
                else if (m_dev == DEVN && m_idx == 8'h72) m_ctrl = io_wdata;
                else if (m_dev == DEVN && m_idx == 8'h73) m_lo = io_wdata;
                else if (m_dev == DEVN && m_idx == 8'h74) begin
                    val = {io_wdata, m_lo};
                    m_hi = io_wdata;
                    ld = 1;
                end
            end
            if (ld) begin
                m_cnt = val;
                m_armed = (val != 0);
            end else if (m_armed && t) begin
                if (m_cnt == 1) begin
                    m_cnt = 0;
                    m_armed = 0;
                    if (ctrl_old[6]) begin
                        if (ctrl_old[7]) m_rst = 1; else m_nmi = 1;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8 R7: pulse pins against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 reset pulse vs model", int'(rst0), int'(m_rst));
            chk("R8 nmi pulse vs model", int'(nmi0), int'(m_nmi));
            if (rst0) n_rst++;
            if (nmi0) n_nmi++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk);
        #1 io_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] e, string tag, bit second = 1'b0);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1 chk(tag, second ? int'(rdata1) : int'(rdata0), int'(e));
        io_rd = 1'b0;
    endtask

    task automatic key(logic [15:0] a, logic [7:0] last);
        wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
    endtask

    task automatic cfg(logic [7:0] i, logic [7:0] v);
        wr(BASE, i); wr(BASE + 1, v);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int r0, m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 reset output low", int'(rst0 | nmi0), 0);
        rd(BASE + 1, 8'hFF, "R10 locked after reset data port");
        rd(BASE, 8'hFF, "R3 locked index read");

        // R2: broken keys keep it locked
        wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h54);
        rd(BASE + 1, 8'hFF, "R2 wrong last byte stays locked");
        wr(BASE, 8'h87); wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h55);
        rd(BASE + 1, 8'hFF, "R2 repeated first byte restarts strictly");
        key(BASE, 8'h55);
        wr(BASE, 8'h20);
        rd(BASE + 1, 8'h87, "R2 R4 open, id byte A");
        wr(BASE, 8'h21);
        rd(BASE + 1, 8'h21, "R4 id byte B");
        rd(BASE, 8'h21, "R1 index readback");
        rd(BASE + 2, 8'h00, "R1 foreign address reads zero");

        // R2: alternate base needs 0xAA
        key(ALT, 8'h55);
        rd(ALT + 1, 8'hFF, "R2 alt base rejects 0x55", 1'b1);
        key(ALT, 8'hAA);
        wr(ALT, 8'h20);
        rd(ALT + 1, 8'h87, "R2 alt base opens with 0xAA", 1'b1);

        // R5: foreign device ignores watchdog registers
        cfg(8'h07, 8'h03);
        rd(BASE + 1, 8'h03, "R4 device select readback");
        cfg(8'h73, 8'h05);
        rd(BASE + 1, 8'h00, "R5 foreign device reads zero");
        cfg(8'h07, DEVN);
        wr(BASE, 8'h73);
        rd(BASE + 1, 8'h00, "R5 write under foreign device ignored");

        // R8: reset pulse
        r0 = n_rst; m0 = n_nmi;
        cfg(8'h72, 8'hC0);
        rd(BASE + 1, 8'hC0, "R5 control readback");
        cfg(8'h73, 8'h03); cfg(8'h74, 8'h00);
        idle(5 * N);
        chk("R8 one reset pulse", n_rst - r0, 1);
        chk("R8 no nmi pulse", n_nmi - m0, 0);

        // R8: nmi pulse
        r0 = n_rst; m0 = n_nmi;
        cfg(8'h72, 8'h40);
        cfg(8'h73, 8'h02); cfg(8'h74, 8'h00);
        idle(4 * N);
        chk("R8 one nmi pulse", n_nmi - m0, 1);
        chk("R8 no reset pulse", n_rst - r0, 0);

        // R6: zero write stops
        r0 = n_rst; m0 = n_nmi;
        cfg(8'h72, 8'hC0);
        cfg(8'h73, 8'h03); cfg(8'h74, 8'h00);
        idle(N);
        cfg(8'h73, 8'h00); cfg(8'h74, 8'h00);
        idle(6 * N);
        chk("R6 zero disarms", n_rst - r0, 0);

        // R6 R7: refreshes hold it off, then it runs out
        cfg(8'h73, 8'h03); cfg(8'h74, 8'h00);
        for (int k = 0; k < 6; k++) begin
            idle(N);
            wr(BASE + 1, 8'h00);
        end
        chk("R7 refresh holds off expiry", n_rst - r0, 0);
        idle(5 * N);
        chk("R7 expiry after refreshes", n_rst - r0, 1);

        // R6: low byte alone does not arm
        r0 = n_rst;
        cfg(8'h73, 8'h01);
        idle(3 * N);
        chk("R6 low byte alone no arm", n_rst - r0, 0);
        wr(BASE, 8'h74); wr(BASE + 1, 8'h00);
        idle(3 * N);
        chk("R6 high write loads coherent value", n_rst - r0, 1);
        wr(BASE, 8'h73);
        rd(BASE + 1, 8'h01, "R6 low shadow readback");

        // R8: disabled output, timer still disarms
        r0 = n_rst; m0 = n_nmi;
        cfg(8'h72, 8'h80);
        cfg(8'h73, 8'h01); cfg(8'h74, 8'h00);
        idle(3 * N);
        cfg(8'h72, 8'hC0);
        idle(4 * N);
        chk("R8 disabled output and disarm", (n_rst - r0) + (n_nmi - m0), 0);

        // R7: high byte counts 256 seconds
        r0 = n_rst;
        cfg(8'h73, 8'h00); cfg(8'h74, 8'h01);
        idle(255 * N - 2);
        chk("R7 no early expiry of 0x100", n_rst - r0, 0);
        idle(3 * N);
        chk("R7 expiry of 0x100", n_rst - r0, 1);

        // R9: exit locks, data write then ignored, key again
        cfg(8'h07, 8'h05);
        cfg(8'h02, 8'h02);
        rd(BASE + 1, 8'hFF, "R9 locked after exit");
        wr(BASE + 1, 8'h07);
        key(BASE, 8'h55);
        wr(BASE, 8'h07);
        rd(BASE + 1, 8'h05, "R3 locked data write ignored");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule